// File: doc/BRIEF.md
# Split-Clock Decade Ripple Counter

This block is a four-bit counter made of two sections that share no clock. One section is a single flip-flop that divides by two. The other is three flip-flops that divide by five. Each section advances on the falling edge of its own clock input. The four state bits sit on the outputs: `q_div2` is bit 0, and `q_div5` gives bits 3..1. How the count behaves depends on how the sections are joined outside the block. Feed `q_div2` into `tick_div5` and the block counts in BCD from 0 to 9. Feed `q_div5[2]` into `tick_div2` and `q_div2` becomes a divide-by-ten square wave.

Two pairs of asynchronous controls override the count at any moment, with no clock edge needed. When both clear inputs are high, all four bits go to zero. When both load-nine inputs are high, the bits become 1001. The load-nine pair wins over the clear pair.

Top module: `dec_ripple_decade`

## Requirements
- R1: Every falling edge of `tick_div2` inverts `q_div2`, provided no asynchronous control is active.
- R2: On each falling edge of `tick_div5`, `q_div5` (binary, bit 2 most significant) steps 0→1→2→3→4 and then returns to 0.
- R3: A rising edge on either clock input leaves every output unchanged.
- R4: When `clear_a` and `clear_b` are both high, the output {q_div5,q_div2} becomes 4'b0000 at once, between clock edges.
- R5: A clear input that is high while the other clear input is low changes no output.
- R6: When `nine_a` and `nine_b` are both high, {q_div5,q_div2} becomes 4'b1001 at once, between clock edges.
- R7: A load-nine input that is high while the other load-nine input is low changes no output.
- R8: If both pairs are active together, the output is 4'b1001. When the load-nine pair is released and the clear pair is still active, the output becomes 4'b0000.
- R9: While either pair is active, falling clock edges do not change the outputs.
- R10: With `q_div2` wired to `tick_div5`, successive falling edges on `tick_div2` give the values 0 to 9 on {q_div5,q_div2}, and 9 is followed by 0.
- R11: With `q_div5[2]` wired to `tick_div2`, starting from nine, `q_div2` is low for five falling edges of `tick_div5` and then high for five, repeating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tick_div2 | input | 1 | Clock for the divide-by-two section, active on the falling edge |
| tick_div5 | input | 1 | Clock for the divide-by-five section, active on the falling edge |
| clear_a | input | 1 | Asynchronous clear, first input of the pair |
| clear_b | input | 1 | Asynchronous clear, second input of the pair |
| nine_a | input | 1 | Asynchronous load-nine, first input of the pair |
| nine_b | input | 1 | Asynchronous load-nine, second input of the pair |
| q_div2 | output | 1 | Divide-by-two state (count bit 0) |
| q_div5 | output | 3 | Divide-by-five state (count bits 3..1) |

## Verification
The hardest case to reach is an asynchronous control changing inside the gap between clock edges while a section is wired back to the other, so that the forced output is also a clock. The control can then cause an edge of its own. The bench does all mode rewiring while the clear pair is held, so that any edge caused by the rewiring is ignored. It applies and releases each control half a cycle away from any driven edge and checks the outputs before the next edge. The overlap of both pairs, followed by the release of load-nine alone, is driven as its own step.

// File: rtl/dec_pkg.sv
`timescale 1ns/1ps
package dec_pkg;
    localparam int DIV5_BITS    = 3;
    localparam int CNT_BITS     = DIV5_BITS + 1;
    localparam int FORCE_INPUTS = 2;

    typedef logic [DIV5_BITS-1:0] div5_t;
    typedef logic [CNT_BITS-1:0]  cnt_t;

    localparam div5_t DIV5_TOP    = div5_t'(4);
    localparam cnt_t  PRESET_CODE = cnt_t'(9);

    typedef struct packed {
        logic load9;
        logic zero;
    } force_t;

    function automatic div5_t div5_step(div5_t cur);
        if (cur >= DIV5_TOP) return '0;
        return cur + div5_t'(1);
    endfunction

    function automatic force_t decode_force(logic [FORCE_INPUTS-1:0] clr,
                                            logic [FORCE_INPUTS-1:0] set);
        force_t f;
        f.load9 = &set;
        f.zero  = &clr;
        return f;
    endfunction
endpackage

// File: rtl/dec_force_decode.sv
`timescale 1ns/1ps
module dec_force_decode
    import dec_pkg::*;
(
    input  logic [FORCE_INPUTS-1:0] clr_in,
    input  logic [FORCE_INPUTS-1:0] set_in,
    output logic [CNT_BITS-1:0]     aset_o,
    output logic [CNT_BITS-1:0]     aclr_o
);
    force_t req;
    assign req = decode_force(clr_in, set_in);

    // Each bit gets its own asynchronous set and clear, so that a release of
    // load-nine while clear is still held gives a fresh clear edge.
    for (genvar i = 0; i < CNT_BITS; i++) begin : g_bit
        if (PRESET_CODE[i]) begin : g_one
            assign aset_o[i] = req.load9;
            assign aclr_o[i] = req.zero & ~req.load9;
        end else begin : g_zero
            assign aset_o[i] = 1'b0;
            assign aclr_o[i] = req.zero | req.load9;
        end
    end
endmodule

// File: rtl/dec_div2_stage.sv
`timescale 1ns/1ps
module dec_div2_stage (
    input  logic tick,
    input  logic aset,
    input  logic aclr,
    output logic q
);
    always_ff @(negedge tick or posedge aset or posedge aclr) begin
        if (aset)      q <= 1'b1;
        else if (aclr) q <= 1'b0;
        else           q <= ~q;
    end
endmodule

// File: rtl/dec_div5_stage.sv
`timescale 1ns/1ps
module dec_div5_stage
    import dec_pkg::*;
(
    input  logic                 tick,
    input  logic [DIV5_BITS-1:0] aset,
    input  logic [DIV5_BITS-1:0] aclr,
    output logic [DIV5_BITS-1:0] q
);
    div5_t nxt;
    assign nxt = div5_step(q);

    for (genvar i = 0; i < DIV5_BITS; i++) begin : g_ff
        logic st;
        always_ff @(negedge tick or posedge aset[i] or posedge aclr[i]) begin
            if (aset[i])      st <= 1'b1;
            else if (aclr[i]) st <= 1'b0;
            else              st <= nxt[i];
        end
        assign q[i] = st;
    end
endmodule

// File: rtl/dec_ripple_decade.sv
`timescale 1ns/1ps
module dec_ripple_decade
    import dec_pkg::*;
(
    input  logic                 tick_div2,
    input  logic                 tick_div5,
    input  logic                 clear_a,
    input  logic                 clear_b,
    input  logic                 nine_a,
    input  logic                 nine_b,
    output logic                 q_div2,
    output logic [DIV5_BITS-1:0] q_div5
);
    logic [CNT_BITS-1:0] aset;
    logic [CNT_BITS-1:0] aclr;

    dec_force_decode u_force (
        .clr_in ({clear_b, clear_a}),
        .set_in ({nine_b, nine_a}),
        .aset_o (aset),
        .aclr_o (aclr)
    );

    dec_div2_stage u_div2 (
        .tick (tick_div2),
        .aset (aset[0]),
        .aclr (aclr[0]),
        .q    (q_div2)
    );

    dec_div5_stage u_div5 (
        .tick (tick_div5),
        .aset (aset[CNT_BITS-1:1]),
        .aclr (aclr[CNT_BITS-1:1]),
        .q    (q_div5)
    );
endmodule

// File: rtl/dec_ripple_decade_chk.sv
`timescale 1ns/1ps
module dec_ripple_decade_chk (
    input logic       tick_div2,
    input logic       tick_div5,
    input logic       clear_a,
    input logic       clear_b,
    input logic       nine_a,
    input logic       nine_b,
    input logic       q_div2,
    input logic [2:0] q_div5
);
    logic force_any;
    logic armed;
    logic ok2;
    logic ok5;

    assign force_any = (clear_a & clear_b) | (nine_a & nine_b);

    always_ff @(posedge force_any) armed <= 1'b1;

    // Marks that the last event seen was a clock edge with no force after it.
    always_ff @(negedge tick_div2 or posedge force_any) begin
        if (force_any) ok2 <= 1'b0;
        else           ok2 <= 1'b1;
    end

    always_ff @(negedge tick_div5 or posedge force_any) begin
        if (force_any) ok5 <= 1'b0;
        else           ok5 <= 1'b1;
    end

    // R1
    div2_toggle_chk: assert property (@(negedge tick_div2) disable iff (!armed || force_any)
        ok2 |-> (q_div2 != $past(q_div2)));

    // R2
    div5_step_chk: assert property (@(negedge tick_div5) disable iff (!armed || force_any)
        ok5 |-> (($past(q_div5) == 3'd4) ? (q_div5 == 3'd0) : (q_div5 == $past(q_div5) + 3'd1)));

    // R6
    load_nine_chk: assert property (@(negedge tick_div5) disable iff (!armed)
        (nine_a && nine_b) |-> ({q_div5, q_div2} == 4'b1001));

    // R4
    clear_zero_chk: assert property (@(negedge tick_div2) disable iff (!armed)
        (clear_a && clear_b && !(nine_a && nine_b)) |-> ({q_div5, q_div2} == 4'b0000));
endmodule

bind dec_ripple_decade dec_ripple_decade_chk u_chk (
    .tick_div2 (tick_div2),
    .tick_div5 (tick_div5),
    .clear_a   (clear_a),
    .clear_b   (clear_b),
    .nine_a    (nine_a),
    .nine_b    (nine_b),
    .q_div2    (q_div2),
    .q_div5    (q_div5)
);

// File: tb/tb_dec_ripple_decade.sv
`timescale 1ns/1ps
module tb_dec_ripple_decade;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic drv2 = 1'b0, drv5 = 1'b0;
    logic clear_a = 1'b0, clear_b = 1'b0, nine_a = 1'b0, nine_b = 1'b0;
    int   mode = 0; // 0 separate, 1 BCD hookup, 2 symmetric hookup
    logic tick_div2, tick_div5, q_div2;
    logic [2:0] q_div5;
    int total = 0, bad = 0;
    logic       e2;
    int         e5;

    assign tick_div2 = (mode == 2) ? q_div5[2] : drv2;
    assign tick_div5 = (mode == 1) ? q_div2    : drv5;

    dec_ripple_decade dut (
        .tick_div2 (tick_div2), .tick_div5 (tick_div5),
        .clear_a (clear_a), .clear_b (clear_b),
        .nine_a (nine_a), .nine_b (nine_b),
        .q_div2 (q_div2), .q_div5 (q_div5)
    );

    task automatic check(string req, logic [3:0] exp);
        logic [3:0] got;
        got = {q_div5, q_div2};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, got, exp);
        end
    endtask

    function automatic logic [3:0] model();
        return {e5[2:0], e2};
    endfunction

    task automatic mid_cycle();
        @(posedge clk); #1;
    endtask

    task automatic pulse2();
        @(posedge clk); drv2 = 1'b1;
        @(negedge clk); drv2 = 1'b0; #1;
    endtask

    task automatic pulse5();
        @(posedge clk); drv5 = 1'b1;
        @(negedge clk); drv5 = 1'b0; #1;
    endtask

    task automatic step_model5();
        e5 = (e5 == 4) ? 0 : e5 + 1;
    endtask

    task automatic t_reset_state();
        mid_cycle(); clear_a = 1'b1; clear_b = 1'b1; #1;
        check("R4 clear between edges", 4'b0000);
        mid_cycle(); clear_a = 1'b0; clear_b = 1'b0; #1;
        check("R4 state after release", 4'b0000);
        e2 = 1'b0; e5 = 0;
    endtask

    task automatic t_div2();
        for (int k = 0; k < 3; k++) begin
            pulse2(); e2 = ~e2;
            check("R1 toggle", model());
        end
        @(posedge clk); drv2 = 1'b1; #1;
        check("R3 rising edge of div2 clock", model());
        @(negedge clk); drv2 = 1'b0; #1; e2 = ~e2;
        check("R1 toggle after held high", model());
    endtask

    task automatic t_div5();
        for (int k = 0; k < 7; k++) begin
            pulse5(); step_model5();
            check("R2 divide-by-five step", model());
        end
        @(posedge clk); drv5 = 1'b1; #1;
        check("R3 rising edge of div5 clock", model());
        @(negedge clk); drv5 = 1'b0; #1; step_model5();
        check("R2 step after held high", model());
    endtask

    task automatic t_partial();
        mid_cycle(); nine_a = 1'b1; #1;  check("R7 only nine_a", model());
        nine_a = 1'b0; nine_b = 1'b1; #1; check("R7 only nine_b", model());
        nine_b = 1'b0; clear_a = 1'b1; #1; check("R5 only clear_a", model());
        clear_a = 1'b0; clear_b = 1'b1; #1; check("R5 only clear_b", model());
        clear_b = 1'b0; #1;
        pulse5(); step_model5();
        check("R5 counting unaffected after partial inputs", model());
    endtask

    task automatic t_preset();
        mid_cycle(); nine_a = 1'b1; nine_b = 1'b1; #1;
        check("R6 load nine between edges", 4'b1001);
        pulse2(); check("R9 div2 edge while forced", 4'b1001);
        pulse5(); check("R9 div5 edge while forced", 4'b1001);
        mid_cycle(); clear_a = 1'b1; clear_b = 1'b1; #1;
        check("R8 both pairs active", 4'b1001);
        mid_cycle(); nine_a = 1'b0; nine_b = 1'b0; #1;
        check("R8 load-nine released under clear", 4'b0000);
        pulse2(); check("R9 edge while clear held", 4'b0000);
        mid_cycle(); clear_a = 1'b0; clear_b = 1'b0; #1;
        e2 = 1'b0; e5 = 0;
        pulse5(); step_model5();
        check("R2 count resumes from zero", model());
    endtask

    task automatic t_bcd();
        mid_cycle(); clear_a = 1'b1; clear_b = 1'b1; #1;
        mode = 1; #1;
        clear_a = 1'b0; clear_b = 1'b0; #1;
        check("R10 start at zero", 4'b0000);
        for (int k = 1; k <= 12; k++) begin
            pulse2();
            check("R10 BCD count", 4'(k % 10));
        end
        mid_cycle(); nine_a = 1'b1; nine_b = 1'b1; #1;
        nine_a = 1'b0; nine_b = 1'b0; #1;
        check("R6 nine in BCD hookup", 4'b1001);
        pulse2(); check("R10 nine wraps to zero", 4'b0000);
        mid_cycle(); clear_a = 1'b1; clear_b = 1'b1; #1;
        mode = 0; #1;
        clear_a = 1'b0; clear_b = 1'b0; #1;
    endtask

    task automatic t_sym();
        int lows, highs;
        lows = 0; highs = 0;
        mid_cycle(); clear_a = 1'b1; clear_b = 1'b1; #1;
        mode = 2; #1;
        nine_a = 1'b1; nine_b = 1'b1; #1;
        clear_a = 1'b0; clear_b = 1'b0; #1;
        nine_a = 1'b0; nine_b = 1'b0; #1;
        check("R11 start from nine", 4'b1001);
        e2 = 1'b1; e5 = 4;
        for (int k = 0; k < 20; k++) begin
            pulse5(); step_model5();
            if (e5 == 0) e2 = ~e2;
            check("R11 symmetric sequence", model());
            if (q_div2) highs++; else lows++;
        end
        total++;
        if (highs != 10 || lows != 10) begin
            bad++;
            $display("FAIL R11 duty actual=%0d/%0d expected=10/10", highs, lows);
        end
        mid_cycle(); clear_a = 1'b1; clear_b = 1'b1; #1;
        mode = 0; #1;
        clear_a = 1'b0; clear_b = 1'b0; #1;
    endtask

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        e2 = 1'b0; e5 = 0;
        repeat (2) @(posedge clk);
        t_reset_state();
        t_div2();
        t_div5();
        t_partial();
        t_preset();
        t_bcd();
        t_sym();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule